// File: doc/BRIEF.md
# Quadrature Position Counter with Locked Configuration

This block turns two quadrature phase signals into a position count. Both phases are brought into the clock domain by two-flop synchronisers and then sampled at a rate set by a 3-bit prescaler. Every valid change of either phase moves the count by one step (x4 decoding). The direction depends on which phase leads. The count runs between a programmable initial value and a modulo limit, and it wraps at either end. A wrap sets a sticky flag, and so does an illegal double change of the phases.

Software controls the block through a small word-addressed register bus. Reads take one cycle. The configuration registers can be locked in two ways. A write-protect bit is set through the status register and released through a bit in the mode register. A module-enable bit must also be set before the initial-value, modulo and decoder-control registers accept writes. Writing any value to the count register reloads the count from the initial value.

Register addresses: 0 control (bits [2:0] prescale code), 1 count, 2 initial value, 3 modulo, 4 decoder control (bit 0 quadrature enable), 5 mode (bit 0 module enable, bit 2 protect release), 6 status (bit 0 protect, bit 1 wrap flag, bit 2 phase-error flag). Addresses 2 to 4 form the enable-gated range.

Top module: `qdec_timer`

## Requirements
- R1: While counting is enabled, each single change of the synchronised phase pair {A,B} moves the count by one. The sequence 00→10→11→01→00 counts up and the reverse sequence counts down.
- R2: A bus write of any data to address 1 sets the count to the initial-value register (address 2), whatever the write data is.
- R3: Control bits [2:0] hold a prescale code k (0 to 7) that reads back unchanged. The phases are evaluated once every 2^k clocks, so phase changes spaced exactly 2^k clocks apart are each counted, and changes spaced 2^(k-1) clocks apart are flagged as illegal.
- R4: Writing 1 to status bit 0 turns write protection on, and status bit 0 then reads 1. While protection is on, writes to control, initial value, modulo, decoder control and the mode enable bit are ignored. Count reload writes and status flag writes still act.
- R5: Writing 1 to mode bit 2 turns protection off, and status bit 0 then reads 0. Mode bit 2 reads 0.
- R6: While mode bit 0 is 0, writes to addresses 2 to 4 are ignored.
- R7: Counting up from the modulo value loads the initial value, and counting down from the initial value loads the modulo value. Either wrap sets status bit 1. Writing 0 to status bit 1 clears it, and writing 1 leaves it unchanged. With an initial value of 0 and a modulo value of all ones, the count uses its full range.
- R8: A sample in which both phases have changed is not counted and sets status bit 2. Writing 0 to status bit 2 clears it.
- R9: After reset every register reads 0: protection off, module enable 0, quadrature enable 0, count 0, initial value 0, modulo 0 and prescale code 0.
- R10: The count does not move on phase changes while either decoder-control bit 0 or mode bit 0 is 0.
- R11: A read strobe returns the addressed register on the data output after the next clock edge. Back-to-back reads each return their own register, and the count reads back zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| phase_a | input | 1 | Quadrature phase A, asynchronous |
| phase_b | input | 1 | Quadrature phase B, asynchronous |

## Verification
The bench builds the block with a 6-bit count and the default 3-bit prescale field. With that count width, a full-range wrap from 63 to 0 and modulo wraps at both ends are reached in a few dozen steps. It sweeps all eight prescale codes. For each code it spaces phase changes at exactly the division period, which must count every change, and at half that period, which must raise the error flag. This covers the sampling rate without depending on where the free-running divider happens to stand.

// File: rtl/qdec_pkg.sv
// Shared register addresses and bit positions for the quadrature counter.
package qdec_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_INIT = 3'd2;
    localparam logic [ADDR_W-1:0] A_MOD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_QDC  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

    // Writes in this address range need the module-enable bit.
    localparam logic [ADDR_W-1:0] GATE_LO = A_INIT;
    localparam logic [ADDR_W-1:0] GATE_HI = A_QDC;

    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_REL_BIT = 2;
    localparam int STAT_WP_BIT  = 0;
    localparam int STAT_OVF_BIT = 1;
    localparam int STAT_ERR_BIT = 2;
    localparam int QDC_EN_BIT   = 0;
endpackage

// File: rtl/qdec_front.sv
// Phase input stage: two-flop synchronisers, prescaled sampling and x4
// edge decoding. Assumes the phases are asynchronous. The divider runs
// freely and a sample is taken whenever its low k bits are all ones.
module qdec_front #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phase_a,
    input  logic            phase_b,
    input  logic [PS_W-1:0] ps_code,
    input  logic            run,
    output logic            step,
    output logic            step_up,
    output logic            illegal
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [1:0]       raw;
    logic [1:0]       sync1, sync2;
    logic [1:0]       prev_ab;
    logic [1:0]       changed;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic             tick;

    assign raw = {phase_a, phase_b};

    // Two-flop synchroniser for each phase.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync1[g] <= 1'b0;
                sync2[g] <= 1'b0;
            end else begin
                sync1[g] <= raw[g];
                sync2[g] <= sync1[g];
            end
        end
    end

    // Free-running divider that sets the sampling rate.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Sample enable: the low ps_code bits of the divider are all ones.
    always_comb begin
        mask = DIV_W'((32'd1 << ps_code) - 32'd1);
        tick = (div_q & mask) == mask;
    end

    // Last sampled phase pair, kept up to date even while not running.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_ab <= 2'b00;
        else if (tick) prev_ab <= sync2;
    end

    // Decode one sample into a step, its direction and an illegal flag.
    always_comb begin
        changed = sync2 ^ prev_ab;
        step    = run && tick && (changed == 2'b01 || changed == 2'b10);
        illegal = run && tick && (changed == 2'b11);
        step_up = sync2[1] ^ prev_ab[0];
    end

    // R3: with a code above zero, two consecutive cycles never both sample.
    a_r3_tick_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_code != '0) |=> (!tick || ps_code != $past(ps_code)));
endmodule

// File: rtl/qdec_count.sv
// Position counter: reloads from the initial value on a bus write and
// wraps between the initial and modulo values. A reload wins over a step
// in the same cycle. Assumes the initial value is not above the modulo value.
module qdec_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             up,
    input  logic [CNT_W-1:0] init_v,
    input  logic [CNT_W-1:0] mod_v,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic at_top, at_bot;

    // Detect a wrap at either end of the counting range.
    always_comb begin
        at_top = count == mod_v;
        at_bot = count == init_v;
        wrap   = step && !load && ((up && at_top) || (!up && at_bot));
    end

    // Update the count from a reload or a single step.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (load)             count <= init_v;
        else if (step && up)       count <= at_top ? init_v : count + 1'b1;
        else if (step)             count <= at_bot ? mod_v : count - 1'b1;
    end

    // R2: a reload leaves the initial value in the count.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(init_v));
    // R10: without a step or reload the count holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count));
    // R7: stepping up from the modulo value lands on the initial value.
    a_r7_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && up && !load && count == mod_v) |=> count == $past(init_v));
endmodule

// File: rtl/qdec_regs.sv
// Register file: write protection, enable gating of the configuration
// range, sticky flags and a registered read mux. Assumes at most one
// bus access per cycle.
module qdec_regs
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap_evt,
    input  logic              illegal_evt,
    output logic [PS_W-1:0]   ps_code,
    output logic [CNT_W-1:0]  init_v,
    output logic [CNT_W-1:0]  mod_v,
    output logic              run,
    output logic              cnt_load
);
    logic wp_q, en_q, qd_q, ovf_q, err_q;
    logic in_gate, cfg_wr, gated_wr, stat_wr, mode_wr;
    logic wp_set, wp_rel;

    // Decode which writes are allowed this cycle.
    always_comb begin
        in_gate  = bus_addr >= GATE_LO && bus_addr <= GATE_HI;
        cfg_wr   = bus_wr && !wp_q;
        gated_wr = cfg_wr && in_gate && en_q;
        stat_wr  = bus_wr && bus_addr == A_STAT;
        mode_wr  = bus_wr && bus_addr == A_MODE;
        wp_set   = stat_wr && bus_wdata[STAT_WP_BIT];
        wp_rel   = mode_wr && bus_wdata[MODE_REL_BIT];
        cnt_load = bus_wr && bus_addr == A_CNT;
        run      = en_q && qd_q;
    end

    // Write-protect state: setting through status wins over release.
    always_ff @(posedge clk) begin
        if (!rst_n)      wp_q <= 1'b0;
        else if (wp_set) wp_q <= 1'b1;
        else if (wp_rel) wp_q <= 1'b0;
    end

    // Module enable, writable only while unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n)                         en_q <= 1'b0;
        else if (cfg_wr && bus_addr == A_MODE) en_q <= bus_wdata[MODE_EN_BIT];
    end

    // Prescale code, writable only while unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ps_code <= '0;
        else if (cfg_wr && bus_addr == A_CTRL) ps_code <= bus_wdata[PS_W-1:0];
    end

    // Gated configuration: initial value, modulo and quadrature enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_v <= '0;
            mod_v  <= '0;
            qd_q   <= 1'b0;
        end else if (gated_wr) begin
            if (bus_addr == A_INIT) init_v <= bus_wdata[CNT_W-1:0];
            if (bus_addr == A_MOD)  mod_v  <= bus_wdata[CNT_W-1:0];
            if (bus_addr == A_QDC)  qd_q   <= bus_wdata[QDC_EN_BIT];
        end
    end

    // Sticky flags: an event sets them, a written zero clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (wrap_evt)                               ovf_q <= 1'b1;
            else if (stat_wr && !bus_wdata[STAT_OVF_BIT]) ovf_q <= 1'b0;
            if (illegal_evt)                            err_q <= 1'b1;
            else if (stat_wr && !bus_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
        end
    end

    // Registered read mux, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata <= 32'(ps_code);
                A_CNT:   bus_rdata <= 32'(count);
                A_INIT:  bus_rdata <= 32'(init_v);
                A_MOD:   bus_rdata <= 32'(mod_v);
                A_QDC:   bus_rdata <= 32'(qd_q);
                A_MODE:  bus_rdata <= 32'(en_q);
                A_STAT:  bus_rdata <= {29'd0, err_q, ovf_q, wp_q};
                default: bus_rdata <= '0;
            endcase
        end
    end

    // R4: a protected write to the initial value changes nothing.
    a_r4_locked_init: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_q && bus_wr && bus_addr == A_INIT) |=> $stable(init_v));
    // R6: with the module disabled, modulo writes change nothing.
    a_r6_gated_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && bus_wr && bus_addr == A_MOD) |=> $stable(mod_v));
    // R7: the wrap flag stays set until status is written.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !stat_wr) |=> ovf_q);
    // R5: a release write without a set drops protection.
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_rel && !wp_set) |=> !wp_q);
endmodule

// File: rtl/qdec_timer.sv
// Top level: quadrature position counter with a protected register file.
// Assumes a single clock. The phase inputs may change at any time.
module qdec_timer
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              phase_a,
    input  logic              phase_b
);
    logic [PS_W-1:0]  ps_code;
    logic [CNT_W-1:0] init_v, mod_v, count;
    logic             run, cnt_load, step, step_up, illegal, wrap;

    qdec_front #(.PS_W(PS_W)) u_front (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .ps_code(ps_code), .run(run), .step(step), .step_up(step_up),
        .illegal(illegal)
    );

    qdec_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .step(step), .up(step_up),
        .init_v(init_v), .mod_v(mod_v), .count(count), .wrap(wrap)
    );

    qdec_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .wrap_evt(wrap), .illegal_evt(illegal),
        .ps_code(ps_code), .init_v(init_v), .mod_v(mod_v), .run(run),
        .cnt_load(cnt_load)
    );
endmodule

// File: tb/tb_qdec_timer.sv
`timescale 1ns/1ps
module tb_qdec_timer;
    localparam int CW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        qa = 1'b0, qb = 1'b0;

    int total = 0, fails = 0, idx = 0;
    int e_cnt = 0, e_init = 0, e_mod = 0;
    bit done = 0;
    logic [31:0] v, v2;

    always #2 clk = ~clk;

    qdec_timer #(.CNT_W(CW), .PS_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phase_a(qa), .phase_b(qb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive the gray state {a,b} for sequence index 0:00 1:10 2:11 3:01.
    task automatic put_phase();
        case (idx & 3)
            0: begin qa = 1'b0; qb = 1'b0; end
            1: begin qa = 1'b1; qb = 1'b0; end
            2: begin qa = 1'b1; qb = 1'b1; end
            default: begin qa = 1'b0; qb = 1'b1; end
        endcase
    endtask

    task automatic ph(input bit up, input int gap);
        idx = up ? idx + 1 : idx + 3;
        put_phase();
        settle(gap);
    endtask

    function automatic int nxt(input int c, input bit up);
        if (up) return (c == e_mod) ? e_init : c + 1;
        return (c == e_init) ? e_mod : c - 1;
    endfunction

    task automatic steps(input bit up, input int n, input bit counted);
        for (int i = 0; i < n; i++) begin
            ph(up, 4);
            if (counted) e_cnt = nxt(e_cnt, up);
        end
        settle(8);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R9: reset state of every register
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk($sformatf("R9 reset reg %0d", a), v, 32'd0);
        end

        // R6: gated range ignored while module enable is 0
        wr(3'd2, 5); wr(3'd3, 20); wr(3'd4, 1);
        rd(3'd2, v); chk("R6 init gated", v, 0);
        rd(3'd3, v); chk("R6 mod gated", v, 0);
        rd(3'd4, v); chk("R6 qdc gated", v, 0);
        wr(3'd5, 1);
        rd(3'd5, v); chk("R6 mode enable", v, 1);
        wr(3'd2, 5); wr(3'd3, 20); wr(3'd4, 1);
        e_init = 5; e_mod = 20;

        // R11: back-to-back reads return their own registers
        bus_addr = 3'd2; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata; bus_addr = 3'd3;
        @(negedge clk);
        bus_rd = 1'b0; v2 = bus_rdata;
        chk("R11 back-to-back first", v, 5);
        chk("R11 back-to-back second", v2, 20);
        rd(3'd4, v); chk("R6 qdc written", v, 1);

        // R2: write data ignored, count reloads from initial value
        wr(3'd1, 32'h2A); e_cnt = e_init;
        rd(3'd1, v); chk("R2 reload", v, 32'(e_cnt));

        // R1: x4 counting in both directions
        steps(1, 10, 1);
        rd(3'd1, v); chk("R1 up", v, 32'(e_cnt));
        steps(0, 3, 1);
        rd(3'd1, v); chk("R1 down", v, 32'(e_cnt));

        // R7: wraps and sticky flag
        steps(1, 8, 1);
        rd(3'd1, v); chk("R7 at modulo", v, 32'(e_cnt));
        rd(3'd6, v); chk("R7 no flag yet", v, 0);
        steps(1, 1, 1);
        rd(3'd1, v); chk("R7 up wrap", v, 32'(e_cnt));
        rd(3'd6, v); chk("R7 flag on up wrap", v, 2);
        wr(3'd6, 0);
        rd(3'd6, v); chk("R7 flag cleared", v, 0);
        steps(0, 1, 1);
        rd(3'd1, v); chk("R7 down wrap", v, 32'(e_cnt));
        wr(3'd6, 32'h6);
        rd(3'd6, v); chk("R7 write 1 keeps flag", v, 2);
        wr(3'd6, 0);

        // R10: disabled counting holds the count
        wr(3'd4, 0);
        steps(1, 3, 0);
        rd(3'd1, v); chk("R10 quad disabled", v, 32'(e_cnt));
        wr(3'd4, 1); wr(3'd5, 0);
        steps(1, 3, 0);
        rd(3'd1, v); chk("R10 module disabled", v, 32'(e_cnt));
        wr(3'd5, 1);

        // R8: double change ignored, error flag set
        idx = idx + 2; put_phase(); settle(8);
        rd(3'd1, v); chk("R8 illegal not counted", v, 32'(e_cnt));
        rd(3'd6, v); chk("R8 error flag", v, 4);
        steps(1, 1, 1);
        rd(3'd1, v); chk("R8 legal after illegal", v, 32'(e_cnt));
        wr(3'd6, 0);
        rd(3'd6, v); chk("R8 flags cleared", v, 0);

        // R3 and R7: full range, prescale sweep
        wr(3'd2, 0); wr(3'd3, 63); e_init = 0; e_mod = 63;
        wr(3'd1, 0); e_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            wr(3'd0, 32'(k));
            rd(3'd0, v); chk($sformatf("R3 code readback %0d", k), v, 32'(k));
            for (int i = 0; i < 6; i++) begin
                ph(1, 1 << k);
                e_cnt = nxt(e_cnt, 1);
            end
            settle(300);
            rd(3'd1, v); chk($sformatf("R3 spaced count k=%0d", k), v, 32'(e_cnt));
            if (k > 0) begin
                for (int i = 0; i < 4; i++) ph(1, 1 << (k - 1));
                settle(300);
                rd(3'd6, v); chk($sformatf("R3 fast changes flagged k=%0d", k), v & 4, 4);
                wr(3'd6, 0);
                wr(3'd1, 0); e_cnt = 0;
            end
        end
        wr(3'd0, 0);
        for (int i = 0; i < 63; i++) begin
            ph(0, 4);
            e_cnt = nxt(e_cnt, 0);
        end
        settle(8);
        rd(3'd1, v); chk("R7 full range down wrap", v, 32'(e_cnt));
        wr(3'd1, 0); e_cnt = 0; wr(3'd6, 0);

        // R4: protection blocks configuration writes
        wr(3'd6, 1);
        rd(3'd6, v); chk("R4 protect bit", v, 1);
        wr(3'd2, 9);
        rd(3'd2, v); chk("R4 init locked", v, 0);
        wr(3'd0, 3);
        rd(3'd0, v); chk("R4 ctrl locked", v, 0);
        wr(3'd5, 0);
        rd(3'd5, v); chk("R4 mode locked", v, 1);
        steps(1, 2, 1);
        rd(3'd1, v); chk("R4 still counting", v, 32'(e_cnt));
        wr(3'd1, 32'hFF); e_cnt = e_init;
        rd(3'd1, v); chk("R4 reload while locked", v, 32'(e_cnt));

        // R5: release through the mode register
        wr(3'd5, 32'h5);
        rd(3'd6, v); chk("R5 protect released", v, 0);
        rd(3'd5, v); chk("R5 release bit reads 0", v, 1);
        wr(3'd2, 9);
        rd(3'd2, v); chk("R5 init writable", v, 9);

        done = 1;
        summary();
        $finish;
    end
endmodule